// File: doc/BRIEF.md
# Bit-Plane Block Decompressor

This block turns one 32-bit compressed word back into a block of eight 8-bit pixels, four wide and two tall, within a single clock cycle. It is meant for the read path of a frame store that holds reference pixels in compressed form. When a word arrives with its valid strobe, the block splits it into a mode, a start plane, one selector for each 2×2 half and one 12-bit coded field for each half. It then rebuilds every bit plane of both halves and registers the pixels one cycle later.

The two-bit mode alone fixes the three top planes of every pixel. The start plane says where decoding begins in the low five planes. Each half is decoded independently. It is either a list of four indices into one of three fixed 8-entry tables of 2×2 patterns, or three raw 4-bit planes. The planes below the last decoded one are filled with a mid value.

Top module: `bitplane_decomp`

## Requirements
- R1: While `rst` is high at a rising clock edge, `validOut` is 0 and `pixOut` is all zero after that edge.
- R2: `validOut` equals the value `validIn` had at the previous rising edge, so each decoded block appears exactly one cycle after its word.
- R3: When `validIn` is low at an edge, `pixOut` keeps its previous value, whatever `wordIn` holds.
- R4: Bits 7, 6 and 5 of every pixel are set by `wordIn[31:30]`. Mode 0 gives 000, mode 1 gives 010, mode 2 gives 100 and mode 3 gives 110.
- R5: `wordIn[29:28]` is the start plane s, and the first decoded plane is bit 4−s. Bit positions between bit 5 and that plane are 0. Both halves use the same s.
- R6: Selector value g in 0..2 (`wordIn[27:26]` for the left half, `wordIn[25:24]` for the right) picks a pattern group. The half's field holds four 3-bit indices, most significant first, and index k gives the plane at bit 4−s−k. Group 0 holds 0,F,3,C,5,A,6,9. Group 1 holds 1,2,4,8,E,D,B,7. Group 2 holds 7,B,D,E,3,C,6,9. Each list runs from index 0 to 7, in hex.
- R7: Selector value 3 marks a raw half. Its field holds three 4-bit planes, most significant first, and plane k goes to bit 4−s−k.
- R8: Decoded planes that would fall below bit 0 are dropped. When at least one bit stays free below the last decoded plane, the highest free bit is 1 and the lower ones are 0.
- R9: Pixel n of the block is `pixOut[8n+7:8n]`, counted row by row from the top-left. The left half is pixels 0,1,4,5 and the right half is 2,3,6,7. Within a 4-bit plane of a half, bit 0 is top-left, bit 1 top-right, bit 2 bottom-left and bit 3 bottom-right.
- R10: The left field is `wordIn[23:12]` and the right field is `wordIn[11:0]`. Each half is decoded with its own selector, so pattern and raw halves can be mixed in one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | `wordIn` holds a word to decode |
| wordIn | input | 32 | Compressed word |
| validOut | output | 1 | `pixOut` holds a newly decoded block |
| pixOut | output | 64 | Eight decoded pixels, row-major |

## Verification
The bench sweeps every start plane, including the case where the last planes fall off bit 0. A design with a wrong plane offset or fill rule would shift bits or leave a stray mid bit there. Every index of every group is decoded, so a single wrong table entry shows up. Raw and pattern halves are mixed within one word, which catches a design that shares one selector across both halves or mirrors the half order. Idle cycles with garbage on the input catch an output register that does not hold its value.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  localparam int WORD_W       = 32;
  localparam int PIX_W        = 8;
  localparam int NUM_PIX      = 8;
  localparam int ROW_PIX      = 4;
  localparam int NUM_HALF     = 2;
  localparam int HALF_PIX     = NUM_PIX / NUM_HALF;
  localparam int HALF_COLS    = ROW_PIX / NUM_HALF;
  localparam int FIELD_W      = 12;
  localparam int SEL_W        = 2;
  localparam int IDX_W        = 3;
  localparam int CODED_PLANES = FIELD_W / IDX_W;
  localparam int RAW_PLANES   = FIELD_W / HALF_PIX;
  localparam int LOW_PLANES   = 5;
  localparam int PLANE_IDX_W  = 3;
  localparam logic [SEL_W-1:0] SEL_RAW = 2'd3;

  typedef struct packed {
    logic                   load;
    logic [1:0]             hiBits;
    logic [PLANE_IDX_W-1:0] topPlane;
  } ctl_t;

  function automatic logic [HALF_PIX-1:0] patLookup(input logic [SEL_W-1:0] grp,
                                                    input logic [IDX_W-1:0] idx);
    logic [HALF_PIX-1:0] p;
    case ({grp, idx})
      5'b00_000: p = 4'h0;  5'b00_001: p = 4'hF;
      5'b00_010: p = 4'h3;  5'b00_011: p = 4'hC;
      5'b00_100: p = 4'h5;  5'b00_101: p = 4'hA;
      5'b00_110: p = 4'h6;  5'b00_111: p = 4'h9;
      5'b01_000: p = 4'h1;  5'b01_001: p = 4'h2;
      5'b01_010: p = 4'h4;  5'b01_011: p = 4'h8;
      5'b01_100: p = 4'hE;  5'b01_101: p = 4'hD;
      5'b01_110: p = 4'hB;  5'b01_111: p = 4'h7;
      5'b10_000: p = 4'h7;  5'b10_001: p = 4'hB;
      5'b10_010: p = 4'hD;  5'b10_011: p = 4'hE;
      5'b10_100: p = 4'h3;  5'b10_101: p = 4'hC;
      5'b10_110: p = 4'h6;  5'b10_111: p = 4'h9;
      default:   p = 4'h0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bpd_ctrl.sv
module bpd_ctrl
  import bpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic [1:0] modeIn,
  input  logic [1:0] startIn,
  output ctl_t       ctl,
  output logic       validOut
);
  localparam logic [PLANE_IDX_W-1:0] TOP_LOW = PLANE_IDX_W'(LOW_PLANES - 1);

  always_comb begin
    ctl.load     = validIn;
    ctl.hiBits   = modeIn;
    ctl.topPlane = TOP_LOW - {1'b0, startIn};
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end
endmodule

// File: rtl/bpd_half.sv
module bpd_half
  import bpd_pkg::*;
(
  input  logic [SEL_W-1:0]                 sel,
  input  logic [FIELD_W-1:0]               field,
  input  logic [PLANE_IDX_W-1:0]           topPlane,
  output logic [HALF_PIX*LOW_PLANES-1:0]   lowBits
);
  logic [HALF_PIX-1:0] planes [CODED_PLANES];
  logic isRaw;

  assign isRaw = (sel == SEL_RAW);

  for (genvar k = 0; k < CODED_PLANES; k++) begin : g_plane
    if (k < RAW_PLANES) begin : g_both
      assign planes[k] = isRaw ? field[FIELD_W-1-HALF_PIX*k -: HALF_PIX]
                               : patLookup(sel, field[FIELD_W-1-IDX_W*k -: IDX_W]);
    end else begin : g_coded
      assign planes[k] = isRaw ? '0
                               : patLookup(sel, field[FIELD_W-1-IDX_W*k -: IDX_W]);
    end
  end

  always_comb begin
    int nPlanes;
    int d;
    nPlanes = isRaw ? RAW_PLANES : CODED_PLANES;
    lowBits = '0;
    for (int j = 0; j < HALF_PIX; j++) begin
      for (int b = 0; b < LOW_PLANES; b++) begin
        d = int'(topPlane) - b;
        if (d < 0)             lowBits[j*LOW_PLANES + b] = 1'b0;
        else if (d < nPlanes)  lowBits[j*LOW_PLANES + b] = planes[d[1:0]][j];
        else if (d == nPlanes) lowBits[j*LOW_PLANES + b] = 1'b1;
        else                   lowBits[j*LOW_PLANES + b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bpd_datapath.sv
module bpd_datapath
  import bpd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  ctl_t                     ctl,
  input  logic [WORD_W-1:0]        wordIn,
  output logic [NUM_PIX*PIX_W-1:0] pixOut
);
  localparam int SEL_TOP   = WORD_W - 1 - 2*SEL_W;
  localparam int FIELD_TOP = SEL_TOP - NUM_HALF*SEL_W;

  logic [HALF_PIX*LOW_PLANES-1:0] lowBits [NUM_HALF];
  logic [NUM_PIX*PIX_W-1:0] nextPix;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    bpd_half u_half (
      .sel      (wordIn[SEL_TOP - SEL_W*h -: SEL_W]),
      .field    (wordIn[FIELD_TOP - FIELD_W*h -: FIELD_W]),
      .topPlane (ctl.topPlane),
      .lowBits  (lowBits[h])
    );
  end

  always_comb begin
    int pix;
    nextPix = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      for (int j = 0; j < HALF_PIX; j++) begin
        pix = (j / HALF_COLS) * ROW_PIX + h * HALF_COLS + (j % HALF_COLS);
        nextPix[pix*PIX_W +: PIX_W] = {ctl.hiBits, 1'b0, lowBits[h][j*LOW_PLANES +: LOW_PLANES]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pixOut <= '0;
    else if (ctl.load) pixOut <= nextPix;
  end
endmodule

// File: rtl/bitplane_decomp.sv
module bitplane_decomp
  import bpd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  input  logic [31:0] wordIn,
  output logic        validOut,
  output logic [63:0] pixOut
);
  ctl_t ctl;

  bpd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .modeIn   (wordIn[31:30]),
    .startIn  (wordIn[29:28]),
    .ctl      (ctl),
    .validOut (validOut)
  );

  bpd_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .wordIn (wordIn),
    .pixOut (pixOut)
  );
endmodule

// File: rtl/bpd_chk.sv
module bpd_chk (
  input logic        clk,
  input logic        rst,
  input logic        validIn,
  input logic [31:0] wordIn,
  input logic        validOut,
  input logic [63:0] pixOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!validOut && pixOut == 64'd0));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    validOut == $past(validIn));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(validIn) |-> $stable(pixOut));

  // R4
  upper_planes_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (pixOut[7:5] == {$past(wordIn[31:30]), 1'b0}
               && pixOut[63:61] == {$past(wordIn[31:30]), 1'b0}
               && pixOut[29:29] == 1'b0));
endmodule

bind bitplane_decomp bpd_chk u_bpd_chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .wordIn   (wordIn),
  .validOut (validOut),
  .pixOut   (pixOut)
);

// File: tb/bitplane_decomp_bench.sv
`timescale 1ns/1ps
module bitplane_decomp_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [31:0] wordIn;
  logic        validOut;
  logic [63:0] pixOut;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic        expValid = 1'b0;
  logic [63:0] expPix = '0;
  string       pendTag = "R1";

  int grpTab [3][8] = '{
    '{4'h0, 4'hF, 4'h3, 4'hC, 4'h5, 4'hA, 4'h6, 4'h9},
    '{4'h1, 4'h2, 4'h4, 4'h8, 4'hE, 4'hD, 4'hB, 4'h7},
    '{4'h7, 4'hB, 4'hD, 4'hE, 4'h3, 4'hC, 4'h6, 4'h9}
  };

  always #2 clk = ~clk;

  bitplane_decomp u_bitplane_decomp (
    .clk(clk), .rst(rst), .validIn(validIn), .wordIn(wordIn),
    .validOut(validOut), .pixOut(pixOut)
  );

  function automatic logic [63:0] refDecode(input logic [31:0] w);
    logic [63:0] res = '0;
    int mode = w[31:30];
    int sp   = w[29:28];
    for (int h = 0; h < 2; h++) begin
      int sel   = (h == 0) ? int'(w[27:26]) : int'(w[25:24]);
      int field = (h == 0) ? int'(w[23:12]) : int'(w[11:0]);
      for (int j = 0; j < 4; j++) begin
        int low = 0;
        int pos = 4 - sp;
        int n = (sel == 3) ? 3 : 4;
        int row = j / 2;
        int col = h * 2 + j % 2;
        for (int k = 0; k < n; k++) begin
          int bitv;
          if (sel == 3) bitv = (field >> (8 - 4*k + j)) & 1;
          else          bitv = (grpTab[sel][(field >> (9 - 3*k)) & 7] >> j) & 1;
          if (pos >= 0) low = low | (bitv << pos);
          pos = pos - 1;
        end
        if (pos >= 0) low = low | (1 << pos);
        res[(row*4 + col)*8 +: 8] = 8'((mode << 6) | low);
      end
    end
    return res;
  endfunction

  task automatic compare();
    checks++;
    if (validOut !== expValid) begin
      bad++;
      $display("FAIL R2 (%s): validOut=%0b expected %0b", pendTag, validOut, expValid);
    end
    checks++;
    if (pixOut !== expPix) begin
      bad++;
      $display("FAIL %s: pixOut=%h expected %h", pendTag, pixOut, expPix);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input string tag);
    @(negedge clk);
    compare();
    validIn = v;
    wordIn  = w;
    expValid = v;
    if (v) expPix = refDecode(w);
    pendTag = tag;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    validIn = 1'b0;
    wordIn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare();
    rst = 1'b0;

    // R4: every mode
    for (int m = 0; m < 4; m++)
      step(1'b1, {2'(m), 2'd0, 2'd3, 2'd3, 12'hABC, 12'h5A5}, "R4");
    // R5: every start plane
    for (int s = 0; s < 4; s++)
      step(1'b1, {2'd1, 2'(s), 2'd0, 2'd3, 12'h053, 12'hC3F}, "R5");
    // R6: all indices of all groups
    for (int g = 0; g < 3; g++)
      for (int s = 0; s < 2; s++)
        step(1'b1, {2'd2, 2'(s), 2'(g), 2'(g), 12'h053, 12'h977}, "R6");
    // R7: raw planes at every start plane
    for (int s = 0; s < 4; s++)
      step(1'b1, {2'd3, 2'(s), 2'd3, 2'd3, 12'h9E1, 12'h72C}, "R7");
    // R8: fill and truncation
    step(1'b1, {2'd0, 2'd0, 2'd1, 2'd3, 12'hFFF, 12'hFFF}, "R8");
    step(1'b1, {2'd0, 2'd3, 2'd1, 2'd3, 12'hFFF, 12'hFFF}, "R8");
    step(1'b1, {2'd0, 2'd2, 2'd0, 2'd3, 12'h000, 12'h000}, "R8");
    // R9: distinct single-bit raw planes per pixel position
    step(1'b1, {2'd0, 2'd0, 2'd3, 2'd3, 12'h124, 12'h812}, "R9");
    step(1'b1, {2'd0, 2'd1, 2'd3, 2'd3, 12'h800, 12'h001}, "R9");
    // R3: idle cycles with garbage input
    step(1'b0, 32'hFFFF_FFFF, "R3");
    step(1'b0, 32'h1234_5678, "R3");
    // R10: mixed halves
    step(1'b1, {2'd1, 2'd0, 2'd0, 2'd3, 12'h977, 12'h9E1}, "R10");
    step(1'b1, {2'd2, 2'd1, 2'd3, 2'd2, 12'h9E1, 12'h053}, "R10");
    for (int i = 0; i < 300; i++)
      step(1'($urandom_range(0, 3) != 0), $urandom, "R10");
    step(1'b0, 32'd0, "R3");
    step(1'b0, 32'd0, "R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule